// File: doc/BRIEF.md
# Boxcar I/Q Decimator

This block lowers the sample rate of a complex baseband stream. It adds up consecutive I samples and, separately, consecutive Q samples over a block of N accepted inputs, where N is the decimation factor. When the block is complete it emits one I/Q pair and starts the next block from zero. The filter is a single boxcar. Its impulse response is exactly N input samples long, which is the shortest one possible at this output rate. Passband flatness is given up to get that short response.

The block uses an input valid strobe, so it can sit behind a front end that produces samples at irregular intervals. The decimation factor is read from a runtime input when a block begins. The output scale is a right shift taken from another runtime input. After the shift, the result is truncated to the output width. The accumulators are wide enough that the sum of a full block at the largest factor cannot overflow. A typical use is two coherently sampled real IF channels, each mixed to baseband and then passed through one of these decimators.

Top module: `iq_boxcar_decim`

## Requirements
- R1: After reset, out_valid is 0, out_i and out_q are 0, and the first accepted sample starts a new block.
- R2: For a factor N, out_valid is high for exactly one cycle, on the clock edge after the cycle that accepts the N-th valid sample of a block. It is low at all other times.
- R3: The output value is the exact two's-complement sum of the block's N samples, arithmetically shifted right by shift_sel and truncated to the low OUT_W bits. The sum does not overflow for any input values.
- R4: The I and Q paths sum their own inputs independently of each other, and both paths use the same block boundaries.
- R5: A cycle with in_valid low is neither counted nor summed. The data on in_i and in_q in such a cycle has no effect on any output.
- R6: The factor is sampled from dec_len on the first valid sample of a block. A change to dec_len during a block takes effect only from the next block onward.
- R7: A dec_len of 0 is treated as 1. A dec_len above MAX_DEC is treated as MAX_DEC.
- R8: shift_sel is applied as it stands on the cycle that completes a block. Its value on earlier cycles of the block has no effect.
- R9: Between output strobes, out_i and out_q keep the last values emitted.
- R10: With a factor of 1, every valid input produces one output, equal to the shifted and truncated input sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_len | input | $clog2(MAX_DEC+1) | Requested decimation factor, sampled when a block starts |
| shift_sel | input | $clog2(IN_W+$clog2(MAX_DEC)) | Right-shift amount applied to the block sum |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | IN_W | Signed in-phase sample |
| in_q | input | IN_W | Signed quadrature sample |
| out_valid | output | 1 | One-cycle strobe, one per completed block |
| out_i | output | OUT_W | Scaled in-phase block sum |
| out_q | output | OUT_W | Scaled quadrature block sum |

## Verification
The assertions assume only that in_i and in_q are two's-complement values of IN_W bits and that in_valid is a clean level. Given that, the accumulator bound of at most the sample count times the largest sample magnitude must hold for any data, with no restriction on dec_len or shift_sel. The stimulus draws samples across the full signed range, including blocks made entirely of the most negative value and entirely of the most positive value. It drives garbage data on idle cycles and sweeps every dec_len code, including 0 and codes above the maximum. This keeps the inputs inside those assumptions while still reaching the boundaries they protect.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

  // Factor actually used for a requested code: 0 -> 1, above max -> max.
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned maxv);
    if (req == 0) return 1;
    if (req > maxv) return maxv;
    return req;
  endfunction

endpackage

// File: rtl/boxcar_ctrl.sv
module boxcar_ctrl #(
  parameter int MAX_DEC = 64,
  parameter int DEC_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DEC_W-1:0] dec_len,
  output logic             dump,
  output logic [DEC_W-1:0] cnt_q,
  output logic [DEC_W-1:0] len_q
);

  logic [DEC_W-1:0] req_len;
  logic [DEC_W-1:0] eff_len;
  logic [DEC_W:0]   cnt_next;
  logic             block_start;

  assign req_len     = DEC_W'(boxcar_pkg::clamp_len(32'(dec_len), 32'(MAX_DEC)));
  assign block_start = (cnt_q == '0);
  assign eff_len     = block_start ? req_len : len_q;
  assign cnt_next    = {1'b0, cnt_q} + 1'b1;
  assign dump        = in_valid && (cnt_next == {1'b0, eff_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= DEC_W'(1);
    end else if (in_valid) begin
      cnt_q <= dump ? '0 : cnt_next[DEC_W-1:0];
      if (block_start) len_q <= eff_len;
    end
  end

endmodule

// File: rtl/boxcar_lane.sv
module boxcar_lane #(
  parameter int IN_W    = 12,
  parameter int ACC_W   = 18,
  parameter int OUT_W   = 16,
  parameter int SHIFT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    dump,
  input  logic signed [IN_W-1:0]  sample,
  input  logic [SHIFT_W-1:0]      shift_sel,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [OUT_W-1:0] res_q
);

  // Arithmetic shift, sign extension to a safe width, keep the low OUT_W bits.
  function automatic logic signed [OUT_W-1:0] scale_trunc(
      input logic signed [ACC_W-1:0] v,
      input logic [SHIFT_W-1:0]      s);
    logic signed [ACC_W-1:0]       shifted;
    logic signed [ACC_W+OUT_W-1:0] wide;
    shifted = v >>> s;
    wide    = (ACC_W+OUT_W)'(shifted);
    return $signed(wide[OUT_W-1:0]);
  endfunction

  logic signed [ACC_W-1:0] sum_now;

  assign sum_now = acc_q + ACC_W'(sample);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (in_valid) begin
      acc_q <= dump ? '0 : sum_now;
      if (dump) res_q <= scale_trunc(sum_now, shift_sel);
    end
  end

endmodule

// File: rtl/iq_boxcar_decim.sv
module iq_boxcar_decim #(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 16,
  parameter int MAX_DEC = 64,
  localparam int DEC_W   = $clog2(MAX_DEC + 1),
  localparam int ACC_W   = IN_W + $clog2(MAX_DEC),
  localparam int SHIFT_W = (ACC_W > 1) ? $clog2(ACC_W) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DEC_W-1:0]        dec_len,
  input  logic [SHIFT_W-1:0]      shift_sel,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  localparam int LANES = 2;

  // Internal events brought out by name for the checker.
  logic                    dump_evt;
  logic [DEC_W-1:0]        blk_cnt;
  logic [DEC_W-1:0]        blk_len;
  logic signed [ACC_W-1:0] acc_i_w;
  logic signed [ACC_W-1:0] acc_q_w;

  logic signed [IN_W-1:0]  lane_in  [LANES];
  logic signed [ACC_W-1:0] lane_acc [LANES];
  logic signed [OUT_W-1:0] lane_res [LANES];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  boxcar_ctrl #(
    .MAX_DEC (MAX_DEC),
    .DEC_W   (DEC_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .dec_len  (dec_len),
    .dump     (dump_evt),
    .cnt_q    (blk_cnt),
    .len_q    (blk_len)
  );

  for (genvar ch = 0; ch < LANES; ch++) begin : g_lane
    boxcar_lane #(
      .IN_W    (IN_W),
      .ACC_W   (ACC_W),
      .OUT_W   (OUT_W),
      .SHIFT_W (SHIFT_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .dump      (dump_evt),
      .sample    (lane_in[ch]),
      .shift_sel (shift_sel),
      .acc_q     (lane_acc[ch]),
      .res_q     (lane_res[ch])
    );
  end

  assign acc_i_w = lane_acc[0];
  assign acc_q_w = lane_acc[1];
  assign out_i   = lane_res[0];
  assign out_q   = lane_res[1];

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= dump_evt;
  end

endmodule

// File: rtl/boxcar_chk.sv
module boxcar_chk #(
  parameter int IN_W    = 12,
  parameter int ACC_W   = 18,
  parameter int OUT_W   = 16,
  parameter int DEC_W   = 7,
  parameter int MAX_DEC = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    dump_evt,
  input logic [DEC_W-1:0]        blk_cnt,
  input logic [DEC_W-1:0]        blk_len,
  input logic signed [ACC_W-1:0] acc_i,
  input logic signed [ACC_W-1:0] acc_q,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);

  int lim, ai, aq;
  always_comb begin
    lim = int'(blk_cnt) * (1 << (IN_W - 1));
    ai  = int'(acc_i);
    aq  = int'(acc_q);
  end

  AST_DUMP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) dump_evt |-> in_valid); // R5
  AST_STROBE_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n) dump_evt |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !dump_evt |=> !out_valid); // R2
  AST_CLEAR_AT_DUMP: assert property (@(posedge clk) disable iff (!rst_n) dump_evt |=> (blk_cnt == '0 && acc_i == '0 && acc_q == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(blk_cnt) && $stable(acc_i) && $stable(acc_q))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !dump_evt |=> ($stable(out_i) && $stable(out_q))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (ai <= lim && ai >= -lim && aq <= lim && aq >= -lim)); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (blk_cnt != '0) |-> (blk_len >= 1 && int'(blk_len) <= MAX_DEC && blk_cnt < blk_len)); // R7
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (blk_cnt != '0) |=> $stable(blk_len)); // R6

endmodule

bind iq_boxcar_decim boxcar_chk #(
  .IN_W    (IN_W),
  .ACC_W   (ACC_W),
  .OUT_W   (OUT_W),
  .DEC_W   (DEC_W),
  .MAX_DEC (MAX_DEC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .dump_evt  (dump_evt),
  .blk_cnt   (blk_cnt),
  .blk_len   (blk_len),
  .acc_i     (acc_i_w),
  .acc_q     (acc_q_w),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/sim_iq_boxcar_decim.sv
module sim_iq_boxcar_decim;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 4;
  localparam int OUT_W = 5;
  localparam int MAXD  = 8;
  localparam int DW    = 4;   // $clog2(MAXD+1)
  localparam int SW    = 3;   // $clog2(IN_W + $clog2(MAXD))

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] dec_len = '0;
  logic [SW-1:0] shift_sel = '0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_i, out_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_boxcar_decim #(.IN_W(IN_W), .OUT_W(OUT_W), .MAX_DEC(MAXD)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_len(dec_len), .shift_sel(shift_sel),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  // Bench model state
  int mcnt = 0, mlen = 1, si = 0, sq = 0;
  bit exp_v = 0;
  int exp_i = 0, exp_q = 0;
  string tag = "R1";

  function automatic int fold(input int sum, input int sh);
    int v;
    v = sum >>> sh;
    return v & ((1 << OUT_W) - 1);
  endfunction

  task automatic check_outputs();
    n_chk++;
    if (out_valid !== exp_v) begin
      n_err++;
      $display("FAIL R2 (%s): out_valid=%0b expected %0b", tag, out_valid, exp_v);
    end
    n_chk++;
    if (int'($unsigned(out_i)) != exp_i || int'($unsigned(out_q)) != exp_q) begin
      n_err++;
      $display("FAIL %s: out_i=%0d out_q=%0d expected %0d %0d",
               exp_v ? tag : "R9", $unsigned(out_i), $unsigned(out_q), exp_i, exp_q);
    end
  endtask

  task automatic step(input bit v, input int i, input int q, input int d, input int s);
    @(negedge clk);
    check_outputs();
    in_valid  = v;
    in_i      = IN_W'(i);
    in_q      = IN_W'(q);
    dec_len   = DW'(d);
    shift_sel = SW'(s);
    exp_v = 0;
    if (v) begin
      if (mcnt == 0) mlen = (d == 0) ? 1 : ((d > MAXD) ? MAXD : d);
      si += i; sq += q; mcnt++;
      if (mcnt == mlen) begin
        exp_v = 1;
        exp_i = fold(si, s);
        exp_q = fold(sq, s);
        si = 0; sq = 0; mcnt = 0;
      end
    end
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(0, 15)) - 8;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    check_outputs();

    // R10: factor 1 passthrough, every shift
    tag = "R10";
    for (int s = 0; s < 7; s++)
      for (int k = 0; k < 4; k++) step(1, rnd_s(), rnd_s(), 1, s);

    // R3/R4: sweep all factor codes and shifts, random data, gaps
    tag = "R3";
    for (int d = 0; d < 16; d++)
      for (int s = 0; s < 7; s++)
        for (int k = 0; k < 30; k++)
          step($urandom_range(0, 9) > 2, rnd_s(), rnd_s(), d, s);
    // drain blocks at factor 1
    for (int k = 0; k < 10; k++) step(1, 0, 0, 1, 0);

    // R7: clamp codes 0 and above max, with mid-block code churn
    tag = "R7";
    for (int d = 9; d < 16; d++)
      for (int k = 0; k < 16; k++) step(1, rnd_s(), rnd_s(), d, 0);
    for (int k = 0; k < 6; k++) step(1, 3, -2, 0, 0);

    // R3: extremes at max factor, no overflow
    tag = "R3";
    for (int s = 0; s < 7; s++) begin
      for (int k = 0; k < 8; k++) step(1, -8, 7, 8, s);
      for (int k = 0; k < 8; k++) step(1, 7, -8, 8, s);
    end

    // R4: Q idle at zero while I is driven hard
    tag = "R4";
    for (int k = 0; k < 24; k++) step(1, -8, 0, 6, 0);

    // R5: long gaps with garbage on idle cycles
    tag = "R5";
    for (int k = 0; k < 60; k++) begin
      step(1, rnd_s(), rnd_s(), 3, 1);
      for (int g = 0; g < 3; g++) step(0, rnd_s(), rnd_s(), 3, 1);
    end

    // R6: change dec_len after the first sample of a block
    tag = "R6";
    for (int r = 0; r < 8; r++) begin
      step(1, rnd_s(), rnd_s(), 4, 0);
      for (int k = 0; k < 3; k++) step(1, rnd_s(), rnd_s(), 2 + r % 5, 0);
      for (int k = 0; k < 8; k++) step(1, rnd_s(), rnd_s(), 8, 0);
    end

    // R8: shift changes mid-block; only the completing cycle counts
    tag = "R8";
    for (int r = 0; r < 7; r++) begin
      for (int k = 0; k < 4; k++) step(1, 7, -8, 5, 6 - k);
      step(1, 7, -8, 5, r);
    end

    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule